// File: doc/BRIEF.md
# Configurable Transmit Word Packer

This block sits between a transmit FIFO and a serial shifter. It takes one 32-bit FIFO entry at a time and cuts it into protocol words. Four programmable slice descriptors, held in two configuration registers, control the cutting. Each descriptor picks up to eight bits of the entry from a start index, walking either downward or upward. A stop flag on a descriptor closes the protocol word being built. The slices that lie between stop flags are joined into one word of up to 32 bits. A granularity setting then trims that word to 8, 16 or 32 bits.

Both data sides use a valid/ready handshake. An entry is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while an entry is being worked through. Only one descriptor is handled per cycle. A word is handed on on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending word and its valid stay put and no further descriptor is handled. Configuration uses a plain write strobe, and writes have effect only while the packer is idle.

Top module: `tx_word_packer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `cfg_err` is 0. The default configuration emits each byte of an entry as its own word, lowest byte first.
- R2: A descriptor is 10 bits: start index in bits 9:5, direction in bit 4, length minus one in bits 3:1 and stop in bit 0. Address 0 holds descriptors 0 and 1 at bits 9:0 and 19:10. Address 1 holds descriptors 2 and 3 at the same positions. Address 2 holds the granularity code in bits 1:0.
- R3: With direction 1, bits are taken from the start index downward, and the first bit taken becomes the slice MSB. With direction 0, bits are taken upward, and the first bit taken becomes the slice LSB. Bit indices wrap modulo 32.
- R4: A direction-1 slice shifts the partial word left by its length and fills the low bits. A direction-0 slice is placed just above the bits gathered so far.
- R5: Each descriptor with stop set emits one word. The highest-numbered descriptor with stop set is the last one used. The entry is then released, and descriptors above it are ignored.
- R6: The emitted word keeps its low 8 bits for granularity 0, its low 16 bits for granularity 1, and all 32 bits for granularity 2. The remaining bits are zero.
- R7: Granularity code 3, or a configuration with no stop flag at all, sets `cfg_err`. `cfg_err` stays set until reset, and while it is set `in_ready` and `out_valid` are held low.
- R8: A configuration write made while an entry is held or a word is pending is dropped.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and the entry held is not released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | FIFO entry valid |
| in_ready | output | 1 | Packer can take an entry |
| in_data | input | 32 | FIFO entry |
| out_valid | output | 1 | Protocol word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Assembled protocol word |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Two functions can fall in the same cycle: output back-pressure and a configuration write. The bench stalls `out_ready` while a word is pending and an entry is half processed. In that window it writes a new descriptor set. It then checks that the stalled word holds and that every word of that entry and of the next one still follows the old configuration. A second overlap pairs an illegal granularity write with an offered entry. The bench judges it by seeing no accepted entry and no output word.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam int WORD_W  = 32;
  localparam int NVEC    = 4;
  localparam int VEC_W   = 10;
  localparam int SLICE_W = 8;
  localparam int IDX_W   = $clog2(NVEC);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int POS_W   = BIT_W + 1;

  typedef struct packed {
    logic [BIT_W-1:0] start;
    logic             dn;
    logic [2:0]       lenm1;
    logic             stop;
  } pvec_t;

  typedef enum logic [1:0] {
    GR_8  = 2'd0,
    GR_16 = 2'd1,
    GR_32 = 2'd2,
    GR_BAD = 2'd3
  } gran_e;

  function automatic logic [WORD_W-1:0] gran_mask(input gran_e g);
    case (g)
      GR_8:    gran_mask = WORD_W'(32'h0000_00FF);
      GR_16:   gran_mask = WORD_W'(32'h0000_FFFF);
      default: gran_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/tpk_cfg.sv
module tpk_cfg
  import tpk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [1:0]             addr,
  input  logic [31:0]            wdata,
  input  logic                   idle,
  output pvec_t [NVEC-1:0]       vecs,
  output gran_e                  gran,
  output logic [IDX_W-1:0]       last_idx,
  output logic                   err
);
  localparam int NREG = NVEC / 2;
  localparam logic [VEC_W-1:0] DEF_LO = VEC_W'(10'h00F);

  logic [31:0] regs [NREG];
  logic        any_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        regs[r] <= {12'd0, VEC_W'(DEF_LO | (VEC_W'(2*r+1) << 8)),
                    VEC_W'(DEF_LO | (VEC_W'(2*r) << 8))};
      gran <= GR_8;
    end else if (we && idle) begin
      if (addr == 2'd2) gran <= gran_e'(wdata[1:0]);
      else if (int'(addr) < NREG) regs[addr[0]] <= wdata;
    end
  end

  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    assign vecs[i] = pvec_t'(regs[i/2][(i%2)*VEC_W +: VEC_W]);
  end

  always_comb begin
    last_idx = '0;
    any_stop = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      if (vecs[i].stop) begin
        last_idx = IDX_W'(i);
        any_stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err | (gran == GR_BAD) | !any_stop;
  end

  // R8
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !idle) |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(gran)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/tpk_slice.sv
module tpk_slice
  import tpk_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  pvec_t             v,
  input  logic [WORD_W-1:0] acc,
  input  logic [POS_W-1:0]  pos,
  output logic [WORD_W-1:0] acc_nxt,
  output logic [POS_W-1:0]  pos_nxt
);
  logic [SLICE_W-1:0] raw;
  logic [SLICE_W-1:0] val;
  logic [3:0]         len;

  for (genvar k = 0; k < SLICE_W; k++) begin : g_tap
    logic [BIT_W-1:0] bidx;
    assign bidx   = v.dn ? (v.start - BIT_W'(k)) : (v.start + BIT_W'(k));
    assign raw[k] = word[bidx];
  end

  assign len = {1'b0, v.lenm1} + 4'd1;

  always_comb begin
    val = '0;
    for (int k = 0; k < SLICE_W; k++) begin
      if (3'(k) <= v.lenm1) begin
        if (v.dn) val[v.lenm1 - 3'(k)] = raw[k];
        else      val[k]               = raw[k];
      end
    end
  end

  always_comb begin
    if (v.dn) acc_nxt = (acc << len) | WORD_W'(val);
    else      acc_nxt = acc | (WORD_W'(val) << pos);
    pos_nxt = pos + POS_W'(len);
  end
endmodule

// File: rtl/tpk_seq.sv
module tpk_seq
  import tpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  input  pvec_t [NVEC-1:0]   vecs,
  input  gran_e              gran,
  input  logic [IDX_W-1:0]   last_idx,
  input  logic               err,
  output logic               idle
);
  logic               hold_v;
  logic [WORD_W-1:0]  hold_w;
  logic [IDX_W-1:0]   idx;
  logic [WORD_W-1:0]  acc, acc_nxt;
  logic [POS_W-1:0]   pos, pos_nxt;
  logic               out_vld;
  logic               advance, take;
  pvec_t              cur;

  assign cur      = vecs[idx];
  assign in_ready = !hold_v && !err;
  assign take     = out_vld && out_ready && !err;
  assign advance  = hold_v && !err && (!out_vld || out_ready);
  assign out_valid = out_vld && !err;
  assign idle     = !hold_v && !out_vld;

  tpk_slice u_slice (
    .word    (hold_w),
    .v       (cur),
    .acc     (acc),
    .pos     (pos),
    .acc_nxt (acc_nxt),
    .pos_nxt (pos_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_w   <= '0;
      idx      <= '0;
      acc      <= '0;
      pos      <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      if (in_valid && in_ready) begin
        hold_w <= in_data;
        hold_v <= 1'b1;
        idx    <= '0;
        acc    <= '0;
        pos    <= '0;
      end
      if (take) out_vld <= 1'b0;
      if (advance) begin
        if (cur.stop) begin
          out_data <= acc_nxt & gran_mask(gran);
          out_vld  <= 1'b1;
          acc      <= '0;
          pos      <= '0;
        end else begin
          acc <= acc_nxt;
          pos <= pos_nxt;
        end
        if (idx == last_idx) begin
          hold_v <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_ready) |=> (out_vld && $stable(out_data)));

  // R9
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> hold_v);

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> (idx <= last_idx));

  // R6
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && gran == GR_8) |-> (out_data[WORD_W-1:8] == '0));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!in_ready && !out_valid));
endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer
  import tpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        cfg_err
);
  pvec_t [NVEC-1:0]  vecs;
  gran_e             gran;
  logic [IDX_W-1:0]  last_idx;
  logic              idle;

  tpk_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .idle     (idle),
    .vecs     (vecs),
    .gran     (gran),
    .last_idx (last_idx),
    .err      (cfg_err)
  );

  tpk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .vecs      (vecs),
    .gran      (gran),
    .last_idx  (last_idx),
    .err       (cfg_err),
    .idle      (idle)
  );
endmodule

// File: tb/test_tx_word_packer.sv
module test_tx_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] got [$];

  always #5 clk = ~clk;

  tx_word_packer i_tx_word_packer (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .cfg_err
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_data);

  function automatic logic [9:0] mkv(int st, bit dn, int lenm1, bit stop);
    return {5'(st), dn, 3'(lenm1), stop};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got.delete();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(int n);
    int t = 0;
    while (got.size() < n && t < 200) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_words(string req, logic [31:0] exp [$]);
    check({req, " count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(req, got[i], exp[i]);
    got.delete();
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 cfg_err", cfg_err, 0);
    send(32'hDDCC_BBAA);
    drain(4);
    expect_words("R1 default bytes", '{32'hAA, 32'hBB, 32'hCC, 32'hDD});
  endtask

  task automatic t_halves();
    // R2 layout, R4 upward concatenation, R6 16-bit granularity
    wr(2'd0, {12'd0, mkv(8, 0, 6, 1), mkv(0, 0, 7, 0)});
    wr(2'd1, {12'd0, mkv(24, 0, 6, 1), mkv(16, 0, 7, 0)});
    wr(2'd2, 32'd1);
    send(32'hF234_D678);
    drain(2);
    expect_words("R2 R4 two halves", '{32'h5678, 32'h7234});
    wr(2'd2, 32'd0);
    send(32'hF234_D678);
    drain(2);
    expect_words("R6 byte mask", '{32'h78, 32'h34});
  endtask

  task automatic t_msb23();
    // R3 downward, R4 left-shift concatenation, R5 vector 3 unused
    wr(2'd0, {12'd0, mkv(14, 1, 7, 0), mkv(22, 1, 7, 0)});
    wr(2'd1, {12'd0, mkv(3, 0, 7, 0), mkv(6, 1, 6, 1)});
    wr(2'd2, 32'd2);
    send(32'hFFAB_CDEF);
    drain(1);
    expect_words("R5 R4 23-bit msb first", '{32'h002B_CDEF});
  endtask

  task automatic t_wrap();
    // R3 index wrap both ways
    wr(2'd0, {12'd0, mkv(2, 1, 3, 1), mkv(30, 0, 3, 1)});
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    send(32'h8000_0005);
    drain(2);
    expect_words("R3 wrap", '{32'h6, 32'hB});
  endtask

  task automatic t_stall_write();
    logic [31:0] held;
    // default config back after reset
    do_reset();
    out_ready = 1'b0;
    send(32'h4433_2211);
    repeat (4) @(negedge clk);
    held = out_data;
    check("R9 valid held", out_valid, 1);
    check("R9 data first byte", out_data, 32'h11);
    check("R9 in_ready low", in_ready, 0);
    // R8 write while busy must be dropped
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd2);
    check("R9 data stable", out_data, held);
    out_ready = 1'b1;
    drain(4);
    expect_words("R8 R9 after stall", '{32'h11, 32'h22, 32'h33, 32'h44});
    send(32'h8877_6655);
    drain(4);
    expect_words("R8 config unchanged", '{32'h55, 32'h66, 32'h77, 32'h88});
    check("R8 no error", cfg_err, 0);
  endtask

  task automatic t_err_gran();
    do_reset();
    wr(2'd2, 32'd3);
    @(negedge clk);
    check("R7 gran err", cfg_err, 1);
    check("R7 in_ready", in_ready, 0);
    in_valid = 1'b1; in_data = 32'h1234_5678;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    check("R7 no output", got.size(), 0);
    check("R7 out_valid", out_valid, 0);
    wr(2'd2, 32'd0);
    @(negedge clk);
    check("R7 sticky", cfg_err, 1);
  endtask

  task automatic t_err_nostop();
    do_reset();
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    @(negedge clk);
    check("R7 no stop err", cfg_err, 1);
    check("R7 no stop in_ready", in_ready, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_halves();
    t_msb23();
    t_wrap();
    t_stall_write();
    t_err_gran();
    t_err_nostop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule